// File: doc/BRIEF.md
# Programmable Reference Divider with Shared Output Select

This block turns a stream of reference-clock enable pulses into the comparison frequency of a synthesiser loop. A 4-bit ratio code picks one of fifteen even division ratios. The table is not regular. One half of it holds the powers of two from 2 to 256. The other half holds three times a power of two, from 6 to 384. One code is reserved. The divider gives a single-cycle comparison pulse once per period. It also gives a square wave at the comparison rate with a 50% duty cycle.

The block also drives one shared output pin, which can feed the reference of a second synthesiser. Two control bits choose what drives it: the reference enable stream, the comparison square wave, or a constant high level. The ratio code and the two output bits are captured together on a configuration write strobe. A new ratio waits in a pending register and is applied only when the current period ends, so no period is ever cut short. A write of the reserved code is refused: the last legal ratio stays in force and an error flag is raised.

Top module: `refdiv_outsel`

## Requirements
- R1: With ratio code bit 3 low, codes 0000 to 0111 divide by 2, 4, 8, 16, 32, 64, 128 and 256 in that order: comp_pulse_o goes high for one cycle on every Nth ref_en_i pulse.
- R2: With ratio code bit 3 high, codes 1001 to 1111 divide by 6, 12, 24, 48, 96, 192 and 384 in that order.
- R3: A write of code 1000 leaves the pending ratio unchanged and sets ratio_err_o the cycle after the write. A later write of a legal code clears it.
- R4: A newly written ratio takes effect only at the end of the running period. The period in progress completes with the old ratio.
- R5: comp_sq_o toggles after ratio/2 and after ratio enable pulses of each period, giving a 50% duty cycle.
- R6: With out_en_i=1 and out_sel_i=0 latched, refcomp_o repeats ref_en_i one cycle later.
- R7: With out_en_i=1 and out_sel_i=1 latched, refcomp_o repeats comp_sq_o one cycle later.
- R8: With out_en_i=0 latched, refcomp_o is held high.
- R9: After reset, the output controls are both 1, the ratio is 2 (code 0000), all outputs are 0 and ratio_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | One-cycle pulse per reference period |
| cfg_we_i | input | 1 | Configuration write strobe |
| ratio_code_i | input | 4 | Division ratio code |
| out_en_i | input | 1 | Shared output enable (0 forces high) |
| out_sel_i | input | 1 | Shared output source: 0 reference, 1 comparison |
| comp_pulse_o | output | 1 | Comparison pulse, one cycle per period |
| comp_sq_o | output | 1 | Comparison square wave |
| refcomp_o | output | 1 | Shared reference/comparison output |
| ratio_err_o | output | 1 | Reserved ratio code was written |

## Verification
comp_pulse_o and comp_sq_o change one clock after the edge that samples the terminal or mid-period enable pulse. ratio_err_o settles one clock after the write edge. refcomp_o is one register further on. In reference mode it lags ref_en_i by one clock, and in comparison mode it lags comp_sq_o by one clock. The driver steps one cycle at a time. After each falling edge it applies inputs and pushes the outputs a requirement-level model predicts for the next rising edge. The monitor pops and compares that entry at the following falling edge, so every comparison lands exactly one edge after its stimulus.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned SHIFT_W   = CODE_W - 1;
  localparam int unsigned MAX_RATIO = 3 << ((1 << SHIFT_W) - 1);
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1);

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  localparam code_t RESERVED_CODE = code_t'(1) << SHIFT_W;

  typedef enum logic [1:0] {
    OUT_HIGH = 2'd0,
    OUT_REF  = 2'd1,
    OUT_COMP = 2'd2
  } outsel_e;

  // power of two for top bit low, three times a power of two otherwise
  function automatic ratio_t decode_ratio(input code_t c);
    if (!c[CODE_W-1]) return ratio_t'(2) << c[SHIFT_W-1:0];
    else              return ratio_t'(3) << c[SHIFT_W-1:0];
  endfunction
endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
  import refdiv_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  code_t   code_i,
  input  logic    en_i,
  input  logic    sel_i,
  output ratio_t  pend_ratio_o,
  output logic    err_o,
  output outsel_e mode_o
);
  ratio_t pend_q;
  logic   err_q, en_q, sel_q;
  logic   reserved;

  assign reserved = (code_i == RESERVED_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= ratio_t'(2);
      err_q  <= 1'b0;
      en_q   <= 1'b1;
      sel_q  <= 1'b1;
    end else if (we_i) begin
      en_q  <= en_i;
      sel_q <= sel_i;
      err_q <= reserved;
      if (!reserved) pend_q <= decode_ratio(code_i);
    end
  end

  always_comb begin
    if (!en_q)      mode_o = OUT_HIGH;
    else if (sel_q) mode_o = OUT_COMP;
    else            mode_o = OUT_REF;
  end

  assign pend_ratio_o = pend_q;
  assign err_o        = err_q;

  p_reserved_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && reserved) |=> (err_o && $stable(pend_ratio_o)));

  p_legal_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !reserved) |=> !err_o);

  p_pend_even_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_ratio_o[0] && (pend_ratio_o != '0));
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ref_en_i,
  input  ratio_t pend_ratio_i,
  output logic   pulse_o,
  output logic   sq_o
);
  ratio_t cnt_q, act_q;
  logic   pulse_q, sq_q;
  logic   at_last, at_mid;

  assign at_last = (cnt_q == act_q - 1'b1);
  assign at_mid  = (cnt_q == (act_q >> 1) - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q   <= ratio_t'(2);
      pulse_q <= 1'b0;
      sq_q    <= 1'b0;
    end else begin
      pulse_q <= ref_en_i && at_last;
      if (ref_en_i) begin
        if (at_last) begin
          cnt_q <= '0;
          act_q <= pend_ratio_i;  // ratio swap only at period end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (at_last || at_mid) sq_q <= ~sq_q;
      end
    end
  end

  assign pulse_o = pulse_q;
  assign sq_o    = sq_q;

  p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q);

  p_swap_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(ref_en_i && at_last));

  p_pulse_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_sq_on_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sq_o) |-> $past(ref_en_i));
endmodule

// File: rtl/refdiv_outmux.sv
module refdiv_outmux
  import refdiv_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  outsel_e mode_i,
  input  logic    ref_en_i,
  input  logic    sq_i,
  output logic    out_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else begin
      unique case (mode_i)
        OUT_REF:  out_q <= ref_en_i;
        OUT_COMP: out_q <= sq_i;
        default:  out_q <= 1'b1;
      endcase
    end
  end

  assign out_o = out_q;

  p_off_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OUT_HIGH) |=> out_o);

  p_ref_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OUT_REF) |=> (out_o == $past(ref_en_i)));

  p_comp_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OUT_COMP) |=> (out_o == $past(sq_i)));
endmodule

// File: rtl/refdiv_outsel.sv
module refdiv_outsel
  import refdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_en_i,
  input  logic              cfg_we_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              out_en_i,
  input  logic              out_sel_i,
  output logic              comp_pulse_o,
  output logic              comp_sq_o,
  output logic              refcomp_o,
  output logic              ratio_err_o
);
  ratio_t  pend_ratio;
  outsel_e mode;
  logic    sq;

  refdiv_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .code_i       (ratio_code_i),
    .en_i         (out_en_i),
    .sel_i        (out_sel_i),
    .pend_ratio_o (pend_ratio),
    .err_o        (ratio_err_o),
    .mode_o       (mode)
  );

  refdiv_counter u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ref_en_i     (ref_en_i),
    .pend_ratio_i (pend_ratio),
    .pulse_o      (comp_pulse_o),
    .sq_o         (sq)
  );

  refdiv_outmux u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .ref_en_i (ref_en_i),
    .sq_i     (sq),
    .out_o    (refcomp_o)
  );

  assign comp_sq_o = sq;

  p_defaults_r9: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!comp_pulse_o && !comp_sq_o && !refcomp_o && !ratio_err_o));
endmodule

// File: tb/refdiv_outsel_tb.sv
`timescale 1ns/1ps
module refdiv_outsel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0, we = 1'b0, oen = 1'b0, osel = 1'b0;
  logic [3:0] code = 4'd0;
  logic       pulse, sq, rc, err;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  refdiv_outsel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .cfg_we_i(we),
    .ratio_code_i(code), .out_en_i(oen), .out_sel_i(osel),
    .comp_pulse_o(pulse), .comp_sq_o(sq), .refcomp_o(rc), .ratio_err_o(err)
  );

  // requirement model state
  int m_cnt, m_act, m_pend;
  bit m_sq, m_re, m_rts, m_err;
  string cur_tag = "R9";

  logic [3:0] q_val[$];
  string      q_tag[$];

  function automatic int ratio_of(input logic [3:0] c);
    if (!c[3]) return 2 << c[2:0];
    return 3 << c[2:0];
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {pulse,sq,refcomp,err} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input bit w, input logic [3:0] c, input bit re, input bit rts);
    bit e_pulse, e_rc, last, mid;
    @(negedge clk); #1;
    ref_en = en; we = w; code = c; oen = re; osel = rts;
    e_rc    = !m_re ? 1'b1 : (m_rts ? m_sq : en);
    last    = (m_cnt == m_act - 1);
    mid     = (m_cnt == m_act/2 - 1);
    e_pulse = en && last;
    if (en) begin
      if (last || mid) m_sq = !m_sq;
      if (last) begin m_cnt = 0; m_act = m_pend; end
      else m_cnt++;
    end
    if (w) begin
      m_re = re; m_rts = rts;
      if (c == 4'b1000) m_err = 1'b1;
      else begin m_err = 1'b0; m_pend = ratio_of(c); end
    end
    q_val.push_back({e_pulse, m_sq, e_rc, m_err});
    q_tag.push_back(cur_tag);
  endtask

  task automatic wr(input logic [3:0] c, input bit re, input bit rts);
    cyc(1'b0, 1'b1, c, re, rts);
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) cyc((i % gap) == 0, 1'b0, 4'd0, m_re, m_rts);
  endtask

  always @(negedge clk) begin
    if (q_val.size() > 0) begin
      logic [3:0] v;
      string t;
      v = q_val.pop_front();
      t = q_tag.pop_front();
      check(t, {pulse, sq, rc, err}, v);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    m_cnt = 0; m_act = 2; m_pend = 2; m_sq = 0; m_re = 1; m_rts = 1; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R9 reset", {pulse, sq, rc, err}, 4'b0000);
    // R9/R7: default ratio 2 with comparison square on shared output
    cur_tag = "R9 default"; run(12, 1);
    cur_tag = "R7 default gap2"; run(12, 2);
    // R1 powers of two
    cur_tag = "R1";
    for (int c = 0; c < 8; c++) begin
      wr(4'(c), 1'b1, 1'b1);
      run(3 * ratio_of(4'(c)) + 3, (c % 2) + 1);
    end
    // R2 three times powers of two
    cur_tag = "R2";
    for (int c = 9; c < 16; c++) begin
      wr(4'(c), 1'b1, 1'b1);
      run(2 * ratio_of(4'(c)) + 3, 1);
    end
    // R3 reserved code
    cur_tag = "R3 setup"; wr(4'b1011, 1'b1, 1'b1); run(60, 1);
    cur_tag = "R3 reserved"; wr(4'b1000, 1'b1, 1'b1); run(80, 1);
    cur_tag = "R3 clear"; wr(4'b0001, 1'b1, 1'b1); run(30, 1);
    // R4 mid-period ratio change
    cur_tag = "R4"; wr(4'b0011, 1'b1, 1'b1); run(40, 1);
    run(5, 1); wr(4'b0001, 1'b1, 1'b1); run(40, 1);
    // R5 duty with sparse enables
    cur_tag = "R5"; wr(4'b1010, 1'b1, 1'b1); run(100, 3);
    // R6 reference routed
    cur_tag = "R6"; wr(4'b0010, 1'b1, 1'b0); run(30, 2); run(10, 1);
    // R8 forced high
    cur_tag = "R8"; wr(4'b0010, 1'b0, 1'b1); run(30, 1);
    cur_tag = "R8 rts0"; wr(4'b0010, 1'b0, 1'b0); run(20, 2);
    cur_tag = "R7"; wr(4'b0000, 1'b1, 1'b1); run(20, 1);
    @(negedge clk); @(negedge clk); #1;
    finish_run();
  end
endmodule